// File: doc/BRIEF.md
# Sequenced Reset Output Controller

This block owns the active-low reset line that goes to the host processor while power sequences run. When the reset-mode control is set, any request to start a power-down sequence pulls the host reset low before the sequencer begins removing supplies. This applies to a full descent and also to a partial descent that stops at an intermediate pointer. The reset stays low through the power-down, the low-power state and the early part of the next power-up.

During that power-up, software chooses one of four sequence milestones through a select input. The chosen milestone arms a down-counting timer. A length code sets the number of ticks, and the host reset is released when the last tick arrives. A new power-down request while the timer counts pulls reset low again and discards the count. When the reset-mode control is clear, the host reset simply mirrors the sequencer's own RESET mode.

The sequencer, the event sources and the tick generator sit outside the block. A status output shows while the timer is counting.

Top module: `srst_ctrl`

## Requirements
- R1: With `rst_mode_en` high, a high `pd_full_start` at a clock edge drives `host_rst_n` low from that same edge. The strobe takes priority over every other input.
- R2: With `rst_mode_en` high, a high `pd_part_start` has the same effect as R1. Reset goes low at the sampling edge for a partial descent as well.
- R3: While reset is held and the timer is idle, the timer starts at the edge that samples `pu_evt[trig_sel]` high. Bit 0 is sequence start, bit 1 is domain boundary 1, bit 2 is domain boundary 2 and bit 3 is sequence done. An event bit that is not selected, and any event seen while the timer runs or after release, has no effect.
- R4: `host_rst_n` rises at the edge that samples the N-th `tick` after the trigger edge. A tick before the trigger, or in the same cycle as the trigger, is not counted.
- R5: N equals `BASE_TICKS << len_code`, where `len_code` is sampled at the trigger edge. With the defaults, codes 0 to 7 give 2, 4, 8, ... 256 ticks.
- R6: A power-down strobe (full or partial) while the timer runs clears `tmr_run` and keeps `host_rst_n` low at that edge. The partial count is discarded, so a new trigger is needed.
- R7: With `rst_mode_en` low, `host_rst_n` equals the inverse of `seq_in_reset` one edge later. Power-down strobes and events have no effect. When the mode is switched back on, the reset stays released until the next power-down strobe.
- R8: After reset, `host_rst_n` and `tmr_run` are low and the block waits for a trigger event.
- R9: `tmr_run` is high exactly from the trigger edge to the releasing edge, and `host_rst_n` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_mode_en | input | 1 | Enables early assertion and timed release of host reset |
| seq_in_reset | input | 1 | Sequencer is in its RESET mode (used when mode is off) |
| pd_full_start | input | 1 | Strobe: a full power-down sequence is about to start |
| pd_part_start | input | 1 | Strobe: a partial power-down sequence is about to start |
| pu_evt | input | NUM_EVT | Power-up milestone strobes |
| trig_sel | input | SEL_W | Index of the milestone that arms the timer |
| len_code | input | CODE_W | Timer length code |
| tick | input | 1 | Timer time base strobe |
| host_rst_n | output | 1 | Active-low reset to the host |
| tmr_run | output | 1 | Reset timer is counting |

## Verification
On every cycle, the assertions check several properties. Power-down strobes must pull reset low and stop the timer. The selected milestone must start the timer whenever reset is held. Reset must never rise unless the timer was running, and the timer must never run while reset is high. They also check the bypass relation to the sequencer's RESET mode. A counter in the checker confirms that each release comes after exactly `BASE_TICKS << code` ticks. Only the bench scenarios can show that unselected events and early ticks are ignored, that the longest code holds reset for its full length, and how the block behaves when the mode control is toggled in the middle of a sequence.

// File: rtl/srst_pkg.sv
package srst_pkg;

   typedef enum logic [1:0] {
      ST_HELD = 2'd0,
      ST_RUN  = 2'd1,
      ST_FREE = 2'd2
   } srst_state_e;

endpackage

// File: rtl/srst_evt_pick.sv
module srst_evt_pick #(
   parameter int NUM_EVT = 4,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_EVT-1:0] evt,
   input  logic [SEL_W-1:0]   sel,
   output logic               hit
);

   logic [NUM_EVT-1:0] sel_hot;

   for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_dec
      assign sel_hot[gi] = (sel == SEL_W'(gi));
   end

   assign hit = |(evt & sel_hot);

endmodule

// File: rtl/srst_timer.sv
module srst_timer #(
   parameter int BASE_TICKS = 2,
   parameter int CODE_W     = 3,
   parameter int CNT_W      = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              expire
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len;

   assign len    = CNT_W'(BASE_TICKS) << code;
   assign expire = tick && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= len;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/srst_fsm.sv
module srst_fsm
   import srst_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mode_en,
   input  logic        pd_req,
   input  logic        trig_hit,
   input  logic        expire,
   output srst_state_e state,
   output srst_state_e state_nxt,
   output logic        load,
   output logic        clear
);

   always_comb begin
      state_nxt = state;
      load      = 1'b0;
      clear     = 1'b0;
      if (!mode_en) begin
         state_nxt = ST_FREE;
         clear     = 1'b1;
      end else if (pd_req) begin
         state_nxt = ST_HELD;
         clear     = 1'b1;
      end else begin
         case (state)
            ST_HELD: if (trig_hit) begin
               state_nxt = ST_RUN;
               load      = 1'b1;
            end
            ST_RUN: if (expire) begin
               state_nxt = ST_FREE;
               clear     = 1'b1;
            end
            ST_FREE: state_nxt = ST_FREE;
            default: state_nxt = ST_HELD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_HELD;
      else        state <= state_nxt;
   end

endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
   import srst_pkg::*;
#(
   parameter int NUM_EVT    = 4,
   parameter int SEL_W      = $clog2(NUM_EVT),
   parameter int CODE_W     = 3,
   parameter int BASE_TICKS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_mode_en,
   input  logic               seq_in_reset,
   input  logic               pd_full_start,
   input  logic               pd_part_start,
   input  logic [NUM_EVT-1:0] pu_evt,
   input  logic [SEL_W-1:0]   trig_sel,
   input  logic [CODE_W-1:0]  len_code,
   input  logic               tick,
   output logic               host_rst_n,
   output logic               tmr_run
);

   localparam int MAX_LEN = BASE_TICKS << ((1 << CODE_W) - 1);
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   if (NUM_EVT < 2) begin : g_bad_evt
      $error("srst_ctrl: NUM_EVT must be at least 2");
   end
   if ((1 << SEL_W) < NUM_EVT) begin : g_bad_sel
      $error("srst_ctrl: SEL_W too narrow for NUM_EVT");
   end
   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("srst_ctrl: CODE_W must be 1..4");
   end
   if (BASE_TICKS < 1) begin : g_bad_base
      $error("srst_ctrl: BASE_TICKS must be positive");
   end

   srst_state_e state, state_nxt;
   logic        pd_req, trig_hit, expire, load, clear;
   logic        host_q;

   assign pd_req = pd_full_start | pd_part_start;

   srst_evt_pick #(
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W)
   ) i_pick (
      .evt (pu_evt),
      .sel (trig_sel),
      .hit (trig_hit)
   );

   srst_timer #(
      .BASE_TICKS (BASE_TICKS),
      .CODE_W     (CODE_W),
      .CNT_W      (CNT_W)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .clear  (clear),
      .tick   (tick),
      .code   (len_code),
      .expire (expire)
   );

   srst_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_en   (rst_mode_en),
      .pd_req    (pd_req),
      .trig_hit  (trig_hit),
      .expire    (expire),
      .state     (state),
      .state_nxt (state_nxt),
      .load      (load),
      .clear     (clear)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           host_q <= 1'b0;
      else if (rst_mode_en) host_q <= (state_nxt == ST_FREE);
      else                  host_q <= ~seq_in_reset;
   end

   assign host_rst_n = host_q;
   assign tmr_run    = (state == ST_RUN);

endmodule

// File: rtl/srst_ctrl_chk.sv
module srst_ctrl_chk #(
   parameter int NUM_EVT    = 4,
   parameter int SEL_W      = 2,
   parameter int CODE_W     = 3,
   parameter int BASE_TICKS = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rst_mode_en,
   input logic               seq_in_reset,
   input logic               pd_full_start,
   input logic               pd_part_start,
   input logic [NUM_EVT-1:0] pu_evt,
   input logic [SEL_W-1:0]   trig_sel,
   input logic [CODE_W-1:0]  len_code,
   input logic               tick,
   input logic               host_rst_n,
   input logic               tmr_run
);

   localparam int MAX_LEN = BASE_TICKS << ((1 << CODE_W) - 1);
   localparam int CW      = $clog2(MAX_LEN + 1) + 1;

   logic [CW-1:0]     seen_ticks;
   logic [CODE_W-1:0] armed_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_ticks <= '0;
         armed_code <= '0;
      end else if (!tmr_run) begin
         seen_ticks <= '0;
         armed_code <= len_code;
      end else if (tick) begin
         seen_ticks <= seen_ticks + CW'(1);
      end
   end

   AST_FULL_PD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rst_mode_en && pd_full_start |=> !host_rst_n); // R1

   AST_PART_PD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rst_mode_en && pd_part_start |=> !host_rst_n); // R2

   AST_PD_STOPS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      rst_mode_en && (pd_full_start || pd_part_start) |=> !tmr_run); // R6

   AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_mode_en) && rst_mode_en && !pd_full_start && !pd_part_start
      && !tmr_run && !host_rst_n && pu_evt[trig_sel] |=> tmr_run); // R3

   AST_RISE_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_mode_en) && $rose(host_rst_n) |-> $past(tmr_run)); // R4

   AST_TICK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_mode_en) && $fell(tmr_run) && host_rst_n
      |-> seen_ticks == (CW'(BASE_TICKS) << armed_code)); // R5

   AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_mode_en |=> host_rst_n == !$past(seq_in_reset)); // R7

   AST_RUN_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_run |-> !host_rst_n); // R9

endmodule

bind srst_ctrl srst_ctrl_chk #(
   .NUM_EVT    (NUM_EVT),
   .SEL_W      (SEL_W),
   .CODE_W     (CODE_W),
   .BASE_TICKS (BASE_TICKS)
) i_srst_ctrl_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rst_mode_en   (rst_mode_en),
   .seq_in_reset  (seq_in_reset),
   .pd_full_start (pd_full_start),
   .pd_part_start (pd_part_start),
   .pu_evt        (pu_evt),
   .trig_sel      (trig_sel),
   .len_code      (len_code),
   .tick          (tick),
   .host_rst_n    (host_rst_n),
   .tmr_run       (tmr_run)
);

// File: tb/test_srst_ctrl.sv
`timescale 1ns/1ps
module test_srst_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode, sreset, pf, pp, tk;
   logic [3:0] evt;
   logic [1:0] sel;
   logic [2:0] code;
   logic       host_rst_n, tmr_run;
   int         n_vec = 0;
   int         n_bad = 0;

   always #2 clk = ~clk;

   srst_ctrl i_srst_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .rst_mode_en   (mode),
      .seq_in_reset  (sreset),
      .pd_full_start (pf),
      .pd_part_start (pp),
      .pu_evt        (evt),
      .trig_sel      (sel),
      .len_code      (code),
      .tick          (tk),
      .host_rst_n    (host_rst_n),
      .tmr_run       (tmr_run)
   );

   // layout: req(4) | mode sreset pf pp | evt(4) | sel(2) | code(3) | tick | exp_rst_n exp_run
   localparam int NV = 25;
   localparam logic [19:0] VEC [NV] = '{
      {4'd8, 4'b1000, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b00}, // R8 held after reset
      {4'd4, 4'b1000, 4'b0000, 2'd0, 3'd0, 1'b1, 2'b00}, // R4 tick before trigger ignored
      {4'd3, 4'b1000, 4'b0010, 2'd0, 3'd0, 1'b0, 2'b00}, // R3 unselected event
      {4'd3, 4'b1000, 4'b0001, 2'd0, 3'd0, 1'b0, 2'b01}, // R3 selected event arms
      {4'd4, 4'b1000, 4'b0000, 2'd0, 3'd0, 1'b1, 2'b01}, // R4 first tick
      {4'd9, 4'b1000, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b01}, // R9 running, no tick
      {4'd4, 4'b1000, 4'b0000, 2'd0, 3'd0, 1'b1, 2'b10}, // R4 second tick releases
      {4'd3, 4'b1000, 4'b0001, 2'd0, 3'd0, 1'b1, 2'b10}, // R3 event after release ignored
      {4'd1, 4'b1010, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b00}, // R1 full power-down
      {4'd5, 4'b1000, 4'b0100, 2'd2, 3'd1, 1'b0, 2'b01}, // R5 arm sel 2, 4 ticks
      {4'd5, 4'b1000, 4'b0000, 2'd2, 3'd1, 1'b1, 2'b01}, // R5
      {4'd6, 4'b1010, 4'b0000, 2'd2, 3'd1, 1'b1, 2'b00}, // R6 power-down mid-run
      {4'd3, 4'b1000, 4'b1000, 2'd3, 3'd1, 1'b0, 2'b01}, // R3 arm sel 3
      {4'd5, 4'b1000, 4'b0000, 2'd3, 3'd1, 1'b1, 2'b01}, // R5 tick 1
      {4'd5, 4'b1000, 4'b0000, 2'd3, 3'd1, 1'b1, 2'b01}, // R5 tick 2
      {4'd5, 4'b1000, 4'b0000, 2'd3, 3'd1, 1'b1, 2'b01}, // R5 tick 3
      {4'd5, 4'b1000, 4'b0000, 2'd3, 3'd1, 1'b1, 2'b10}, // R5 tick 4 releases
      {4'd7, 4'b0000, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b10}, // R7 bypass, seq not in reset
      {4'd7, 4'b0100, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b00}, // R7 bypass, seq in reset
      {4'd7, 4'b0110, 4'b0001, 2'd0, 3'd0, 1'b1, 2'b00}, // R7 strobes ignored
      {4'd7, 4'b0000, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b10}, // R7 bypass release
      {4'd7, 4'b1100, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b10}, // R7 mode back on stays free
      {4'd2, 4'b1001, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b00}, // R2 partial power-down
      {4'd3, 4'b1000, 4'b0010, 2'd1, 3'd0, 1'b0, 2'b01}, // R3 arm sel 1
      {4'd7, 4'b0000, 4'b0000, 2'd0, 3'd0, 1'b0, 2'b10}  // R7 mode off mid-run
   };

   task automatic drive(input logic m, s, f, p, input logic [3:0] e,
                        input logic [1:0] sl, input logic [2:0] c, input logic t);
      mode = m; sreset = s; pf = f; pp = p; evt = e; sel = sl; code = c; tk = t;
   endtask

   task automatic check(input string tag, input logic exp_r, input logic exp_run);
      n_vec++;
      if (host_rst_n !== exp_r || tmr_run !== exp_run) begin
         n_bad++;
         $display("FAIL %s host_rst_n=%0b exp %0b tmr_run=%0b exp %0b",
                  tag, host_rst_n, exp_r, tmr_run, exp_run);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   initial begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 3'd0, 1'b0);
      repeat (3) @(posedge clk);
      #1;
      check("R8 during reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      step();
      check("R8 after reset", 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8],
               VEC[i][7:6], VEC[i][5:3], VEC[i][2]);
         step();
         check($sformatf("R%0d vector %0d", VEC[i][19:16], i), VEC[i][1], VEC[i][0]);
      end

      // R5: longest code, 256 ticks
      drive(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 2'd0, 3'd7, 1'b0);
      step();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h1, 2'd0, 3'd7, 1'b0);
      step();
      check("R5 long arm", 1'b0, 1'b1);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 3'd0, 1'b1);
      for (int k = 0; k < 255; k++) step();
      check("R5 255 ticks still held", 1'b0, 1'b1);
      step();
      check("R5 256th tick releases", 1'b1, 1'b0);

      // R4: trigger and tick in the same cycle, tick not counted
      drive(1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 2'd0, 3'd0, 1'b0);
      step();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h1, 2'd0, 3'd0, 1'b1);
      step();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 3'd0, 1'b1);
      step();
      check("R4 same-cycle tick ignored", 1'b0, 1'b1);
      step();
      check("R4 release after two ticks", 1'b1, 1'b0);

      // R8: block reset mid-run
      drive(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 2'd0, 3'd2, 1'b0);
      step();
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h1, 2'd0, 3'd2, 1'b0);
      step();
      rst_n = 1'b0;
      #1;
      check("R8 async reset", 1'b0, 1'b0);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 3'd0, 1'b0);
      step();
      rst_n = 1'b1;
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'h1, 2'd0, 3'd0, 1'b0);
      step();
      check("R8 armable after reset", 1'b0, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog R8 expired: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule